// File: doc/BRIEF.md
# Paged Control Register Bank

This block is the host-facing control register file of a multi-channel line-interface device. A host reaches it over a plain parallel bus with a 5-bit address, 8-bit write and read data, and one-cycle write and read strobes. The 32-address window is shared by four register pages. A page pointer sits at address 1Fh of every page and chooses which page the other 31 addresses reach. Four pointer codes are defined and they are not sequential. Any other code leaves the window empty.

The primary and secondary pages are general configuration storage, and their contents are brought out as flat vectors. The per-channel page holds the per-line controls. These are a jitter-attenuator enable, a jitter-attenuator FIFO depth select, a receive-clock invert and a transmit-clock invert, with one bit per channel in each. The same page holds a sticky line-violation status register, its mask and an interrupt control register. Violation events from the lines set status bits. The interrupt output is raised while any unmasked bit is set. A mode bit chooses whether software clears the status by reading it or by writing ones to it. The tester page only decodes here: its contents live elsewhere, so apart from the pointer it reads as zero.

Top module: `pgreg_bank`

## Requirements
- R1: After reset the pointer reads 00h, every register and control output is 00h, and irq_o is low.
- R2: Address 1Fh is the page pointer. It holds all 8 written bits, and it can be written and read back whatever the pointer value is, including undefined codes.
- R3: Pointer code 00h selects the primary page, AAh the secondary page, 01h the per-channel page and 02h the tester page.
- R4: With any other pointer code, reads of 00h–1Eh return 00h and writes to them change no register in any page.
- R5: In the primary page, addresses 00h–15h are read/write registers that appear on prim_regs_o (address n at bits 8n+7:8n). Addresses 16h–1Eh read 00h and ignore writes.
- R6: In the secondary page, addresses 00h–07h are read/write registers that appear on sec_regs_o (same packing). Addresses 08h–1Eh read 00h and ignore writes.
- R7: In the per-channel page, the read/write registers are: 00h jitter-attenuator enable (ja_en_o), 02h FIFO depth select (ja_depth_o), 11h status mask, 13h receive-clock invert (rclk_inv_o) and 14h transmit-clock invert (tclk_inv_o). Bit n of each belongs to channel n. All other addresses except 12h and 1Eh, including 08h–0Fh, read 00h and ignore writes.
- R8: In the tester page, every address except 1Fh reads 00h and ignores writes.
- R9: Line-violation status sits at per-channel address 12h. A high lv_event_i[n] in a cycle sets bit n at the next clock edge, and the bit stays set until it is cleared under the selected mode.
- R10: Bit 0 of per-channel address 1Eh is the clear mode; bits 7:1 read as 0. With mode 0 (the reset value), a read strobe at 12h returns the current status and then clears every bit. Writes to 12h have no effect in this mode.
- R11: With mode 1, a write to 12h clears exactly the status bits where the write data is 1. Reads do not clear in this mode.
- R12: An event arriving in the same cycle as a clear sets its bit, and the event takes priority over the clear.
- R13: irq_o is high exactly when some status bit is set and its mask bit at 11h is 1. It drops in the cycle after the status is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, one cycle |
| re_i | input | 1 | Read strobe, one cycle |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| lv_event_i | input | 8 | Per-channel line-violation event pulses |
| ja_en_o | output | 8 | Per-channel jitter-attenuator enable |
| ja_depth_o | output | 8 | Per-channel jitter-attenuator FIFO depth select |
| rclk_inv_o | output | 8 | Per-channel receive-clock invert |
| tclk_inv_o | output | 8 | Per-channel transmit-clock invert |
| prim_regs_o | output | 176 | Primary page registers 00h–15h, packed |
| sec_regs_o | output | 64 | Secondary page registers 00h–07h, packed |
| irq_o | output | 1 | Interrupt, high while an unmasked status bit is set |

## Verification
Every address 00h–1Eh is written with an address- and page-dependent pattern under each of the four defined pointer codes and under one undefined code. The readback then separates implemented addresses from reserved ones, and a page that decodes to the wrong storage from one that decodes correctly. After that, writes made through the undefined code with a different pattern are followed by a reread of every real page. This shows whether anything leaked into a page. The status tests use single-bit and multi-bit event patterns under both clear modes, with and without masking. They also place an event in the same cycle as a clear, which shows whether the event survives and whether reads wrongly clear in write mode.

// File: rtl/pgreg_pkg.sv
package pgreg_pkg;
  localparam int AW = 5;

  typedef enum logic [2:0] {
    PG_NONE,
    PG_PRIM,
    PG_SEC,
    PG_CHAN,
    PG_TEST
  } page_e;

  localparam logic [7:0] CODE_PRIM = 8'h00;
  localparam logic [7:0] CODE_SEC  = 8'hAA;
  localparam logic [7:0] CODE_CHAN = 8'h01;
  localparam logic [7:0] CODE_TEST = 8'h02;

  localparam logic [AW-1:0] A_PTR = 5'h1F;

  // per-channel page layout
  localparam logic [AW-1:0] A_JA_EN   = 5'h00;
  localparam logic [AW-1:0] A_JA_DEP  = 5'h02;
  localparam logic [AW-1:0] A_LV_MASK = 5'h11;
  localparam logic [AW-1:0] A_LV_STAT = 5'h12;
  localparam logic [AW-1:0] A_RCK_INV = 5'h13;
  localparam logic [AW-1:0] A_TCK_INV = 5'h14;
  localparam logic [AW-1:0] A_IRQ_CTL = 5'h1E;
endpackage

// File: rtl/pgreg_page_dec.sv
module pgreg_page_dec
  import pgreg_pkg::*;
(
  input  logic [7:0] ptr_i,
  output page_e      page_o
);
  always_comb begin
    unique case (ptr_i)
      CODE_PRIM: page_o = PG_PRIM;
      CODE_SEC:  page_o = PG_SEC;
      CODE_CHAN: page_o = PG_CHAN;
      CODE_TEST: page_o = PG_TEST;
      default:   page_o = PG_NONE;
    endcase
  end
endmodule

// File: rtl/pgreg_store_bank.sv
module pgreg_store_bank #(
  parameter int DW    = 8,
  parameter int AW    = 5,
  parameter int DEPTH = 22
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  output logic [DEPTH*DW-1:0] regs_o
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          hit;
  logic [IW-1:0] idx;
  logic [DW-1:0] mem [DEPTH];

  assign hit = addr_i < AW'(DEPTH);
  assign idx = addr_i[IW-1:0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem[i] <= '0;
      else if (we_i && hit && (idx == IW'(i))) mem[i] <= wdata_i;
    end
    assign regs_o[i*DW +: DW] = mem[i];
  end

  assign rdata_o = hit ? mem[idx] : '0;
endmodule

// File: rtl/pgreg_chan_page.sv
module pgreg_chan_page
  import pgreg_pkg::*;
#(
  parameter int DW  = 8,
  parameter int NCH = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic           re_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [NCH-1:0] event_i,
  output logic [DW-1:0]  rdata_o,
  output logic [NCH-1:0] ja_en_o,
  output logic [NCH-1:0] ja_depth_o,
  output logic [NCH-1:0] rclk_inv_o,
  output logic [NCH-1:0] tclk_inv_o,
  output logic [NCH-1:0] stat_o,
  output logic [NCH-1:0] mask_o,
  output logic           clr_wr_o,
  output logic           irq_o
);
  logic [NCH-1:0] ja_en_q, ja_dep_q, rinv_q, tinv_q, mask_q, stat_q, clr_vec;
  logic           clr_wr_q, stat_acc;

  function automatic logic [DW-1:0] zext(input logic [NCH-1:0] v);
    logic [DW-1:0] r;
    r          = '0;
    r[NCH-1:0] = v;
    return r;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ja_en_q  <= '0;
      ja_dep_q <= '0;
      rinv_q   <= '0;
      tinv_q   <= '0;
      mask_q   <= '0;
      clr_wr_q <= 1'b0;
    end else if (we_i) begin
      unique case (addr_i)
        A_JA_EN:   ja_en_q  <= wdata_i[NCH-1:0];
        A_JA_DEP:  ja_dep_q <= wdata_i[NCH-1:0];
        A_LV_MASK: mask_q   <= wdata_i[NCH-1:0];
        A_RCK_INV: rinv_q   <= wdata_i[NCH-1:0];
        A_TCK_INV: tinv_q   <= wdata_i[NCH-1:0];
        A_IRQ_CTL: clr_wr_q <= wdata_i[0];
        default: ;
      endcase
    end
  end

  // clear vector per mode; events are OR-ed in after the clear
  assign stat_acc = (addr_i == A_LV_STAT);
  always_comb begin
    clr_vec = '0;
    if (stat_acc) begin
      if (clr_wr_q && we_i)       clr_vec = wdata_i[NCH-1:0];
      else if (!clr_wr_q && re_i) clr_vec = '1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_vec) | event_i;
  end

  always_comb begin
    unique case (addr_i)
      A_JA_EN:   rdata_o = zext(ja_en_q);
      A_JA_DEP:  rdata_o = zext(ja_dep_q);
      A_LV_MASK: rdata_o = zext(mask_q);
      A_LV_STAT: rdata_o = zext(stat_q);
      A_RCK_INV: rdata_o = zext(rinv_q);
      A_TCK_INV: rdata_o = zext(tinv_q);
      A_IRQ_CTL: rdata_o = {{(DW-1){1'b0}}, clr_wr_q};
      default:   rdata_o = '0;
    endcase
  end

  assign ja_en_o    = ja_en_q;
  assign ja_depth_o = ja_dep_q;
  assign rclk_inv_o = rinv_q;
  assign tclk_inv_o = tinv_q;
  assign stat_o     = stat_q;
  assign mask_o     = mask_q;
  assign clr_wr_o   = clr_wr_q;
  assign irq_o      = |(stat_q & mask_q);
endmodule

// File: rtl/pgreg_bank.sv
module pgreg_bank
  import pgreg_pkg::*;
#(
  parameter int DW     = 8,
  parameter int NCH    = 8,
  parameter int PRIM_N = 22,
  parameter int SEC_N  = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic                 we_i,
  input  logic                 re_i,
  output logic [DW-1:0]        rdata_o,
  input  logic [NCH-1:0]       lv_event_i,
  output logic [NCH-1:0]       ja_en_o,
  output logic [NCH-1:0]       ja_depth_o,
  output logic [NCH-1:0]       rclk_inv_o,
  output logic [NCH-1:0]       tclk_inv_o,
  output logic [PRIM_N*DW-1:0] prim_regs_o,
  output logic [SEC_N*DW-1:0]  sec_regs_o,
  output logic                 irq_o
);
  logic [7:0]     ptr_q;
  page_e          page;
  logic           ptr_hit, pg_we;
  logic [DW-1:0]  prim_rd, sec_rd, chan_rd;
  logic [NCH-1:0] chan_stat, chan_mask;
  logic           chan_clr_wr;

  assign ptr_hit = (addr_i == A_PTR);
  assign pg_we   = we_i && !ptr_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ptr_q <= CODE_PRIM;
    else if (we_i && ptr_hit) ptr_q <= wdata_i[7:0];
  end

  pgreg_page_dec u_dec (
    .ptr_i  (ptr_q),
    .page_o (page)
  );

  pgreg_store_bank #(.DW(DW), .AW(AW), .DEPTH(PRIM_N)) u_prim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (pg_we && (page == PG_PRIM)),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (prim_rd),
    .regs_o  (prim_regs_o)
  );

  pgreg_store_bank #(.DW(DW), .AW(AW), .DEPTH(SEC_N)) u_sec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (pg_we && (page == PG_SEC)),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (sec_rd),
    .regs_o  (sec_regs_o)
  );

  pgreg_chan_page #(.DW(DW), .NCH(NCH)) u_chan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (pg_we && (page == PG_CHAN)),
    .re_i       (re_i && !ptr_hit && (page == PG_CHAN)),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .event_i    (lv_event_i),
    .rdata_o    (chan_rd),
    .ja_en_o    (ja_en_o),
    .ja_depth_o (ja_depth_o),
    .rclk_inv_o (rclk_inv_o),
    .tclk_inv_o (tclk_inv_o),
    .stat_o     (chan_stat),
    .mask_o     (chan_mask),
    .clr_wr_o   (chan_clr_wr),
    .irq_o      (irq_o)
  );

  // tester page and undefined codes decode to nothing
  always_comb begin
    if (ptr_hit) rdata_o = DW'(ptr_q);
    else begin
      unique case (page)
        PG_PRIM: rdata_o = prim_rd;
        PG_SEC:  rdata_o = sec_rd;
        PG_CHAN: rdata_o = chan_rd;
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/pgreg_bank_chk.sv
module pgreg_bank_chk #(
  parameter int DW  = 8,
  parameter int NCH = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [4:0]     addr_i,
  input logic [DW-1:0]  wdata_i,
  input logic           we_i,
  input logic           re_i,
  input logic [DW-1:0]  rdata_o,
  input logic [NCH-1:0] lv_event_i,
  input logic           irq_o,
  input logic [7:0]     ptr_q,
  input logic [NCH-1:0] chan_stat,
  input logic [NCH-1:0] chan_mask,
  input logic           chan_clr_wr
);
  logic ptr_known, on_chan, stat_clr;
  assign ptr_known = (ptr_q == 8'h00) || (ptr_q == 8'hAA) ||
                     (ptr_q == 8'h01) || (ptr_q == 8'h02);
  assign on_chan   = (ptr_q == 8'h01) && (addr_i == 5'h12);
  assign stat_clr  = on_chan && (chan_clr_wr ? we_i : re_i);

  a_r2_ptr_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 5'h1F) |=> (ptr_q == $past(wdata_i[7:0])));

  a_r4_undef_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ptr_known && addr_i != 5'h1F) |-> (rdata_o == '0));

  a_r5_prim_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q == 8'h00 && addr_i >= 5'h16 && addr_i != 5'h1F) |-> (rdata_o == '0));

  a_r8_tester_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q == 8'h02 && addr_i != 5'h1F) |-> (rdata_o == '0));

  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_clr |=> ((chan_stat & $past(chan_stat)) == $past(chan_stat)));

  a_r10_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_chan && re_i && !chan_clr_wr && lv_event_i == '0) |=> (chan_stat == '0));

  a_r12_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lv_event_i != '0) |=> ((chan_stat & $past(lv_event_i)) == $past(lv_event_i)));

  a_r13_irq_needs_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (chan_mask != '0 && chan_stat != '0));
endmodule

bind pgreg_bank pgreg_bank_chk #(.DW(DW), .NCH(NCH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .we_i        (we_i),
  .re_i        (re_i),
  .rdata_o     (rdata_o),
  .lv_event_i  (lv_event_i),
  .irq_o       (irq_o),
  .ptr_q       (ptr_q),
  .chan_stat   (chan_stat),
  .chan_mask   (chan_mask),
  .chan_clr_wr (chan_clr_wr)
);

// File: tb/pgreg_bank_bench.sv
module pgreg_bank_bench;
  localparam int DW = 8, NCH = 8, PRIM_N = 22, SEC_N = 8;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [4:0]           addr = '0;
  logic [DW-1:0]        wdata = '0;
  logic                 we = 1'b0, re = 1'b0;
  logic [DW-1:0]        rdata;
  logic [NCH-1:0]       ev = '0;
  logic [NCH-1:0]       ja_en, ja_dep, rinv, tinv;
  logic [PRIM_N*DW-1:0] prim;
  logic [SEC_N*DW-1:0]  sec;
  logic                 irq;

  int checks = 0, errors = 0;
  logic [7:0] codes [5] = '{8'h00, 8'hAA, 8'h01, 8'h02, 8'h55};

  always #2 clk = ~clk;

  pgreg_bank u_pgreg_bank (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .re_i(re), .rdata_o(rdata), .lv_event_i(ev), .ja_en_o(ja_en),
    .ja_depth_o(ja_dep), .rclk_inv_o(rinv), .tclk_inv_o(tinv),
    .prim_regs_o(prim), .sec_regs_o(sec), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d, input logic [7:0] e);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1; ev = e;
    @(negedge clk);
    we = 1'b0; ev = '0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] e, output logic [7:0] d);
    @(negedge clk);
    addr = a; re = 1'b1; ev = e;
    #1 d = rdata;
    @(negedge clk);
    re = 1'b0; ev = '0;
    #1;
  endtask

  function automatic logic [7:0] pat(input logic [7:0] code, input int a, input logic [7:0] salt);
    return 8'((a * 37 + int'(code) * 5 + int'(salt)) % 256);
  endfunction

  // expected readback from the page map in the requirements
  function automatic logic [7:0] expect_rd(input logic [7:0] code, input int a, input logic [7:0] d);
    case (code)
      8'h00: return (a <= 'h15) ? d : 8'h00;                   // R5
      8'hAA: return (a <= 'h07) ? d : 8'h00;                   // R6
      8'h01: begin                                             // R7
        if (a == 'h00 || a == 'h02 || a == 'h11 || a == 'h13 || a == 'h14) return d;
        if (a == 'h1E) return d & 8'h01;
        return 8'h00;
      end
      default: return 8'h00;                                   // R8, R4
    endcase
  endfunction

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 outputs", {ja_en, ja_dep, rinv, tinv}, 0);
    chk("R1 prim", (prim == '0), 1);
    rst_n = 1'b1;
    rd(5'h1F, 0, d); chk("R1 ptr", d, 8'h00);
    rd(5'h00, 0, d); chk("R1 prim reg00", d, 8'h00);

    // R2 R3 R5 R6 R7 R8: sweep every page
    foreach (codes[c]) begin
      wr(5'h1F, codes[c], 0);
      rd(5'h1F, 0, d); chk("R2 ptr readback", d, codes[c]);
      for (int a = 0; a < 31; a++) wr(5'(a), pat(codes[c], a, 8'h3C), 0);
      for (int a = 0; a < 31; a++) begin
        rd(5'(a), 0, d);
        chk($sformatf("R3 page %0h addr %0h", codes[c], a), d,
            expect_rd(codes[c], a, pat(codes[c], a, 8'h3C)));
      end
    end
    // R4: undefined-code writes must leave every page untouched
    wr(5'h1F, 8'hC3, 0);
    for (int a = 0; a < 31; a++) wr(5'(a), pat(8'hC3, a, 8'h91), 0);
    rd(5'h1F, 0, d); chk("R2 ptr under undefined code", d, 8'hC3);
    for (int c = 0; c < 4; c++) begin
      wr(5'h1F, codes[c], 0);
      for (int a = 0; a < 31; a++) begin
        rd(5'(a), 0, d);
        chk($sformatf("R4 page %0h addr %0h", codes[c], a), d,
            expect_rd(codes[c], a, pat(codes[c], a, 8'h3C)));
      end
    end
    #1;
    for (int a = 0; a < PRIM_N; a++) chk("R5 prim_regs_o", prim[a*8 +: 8], pat(8'h00, a, 8'h3C));
    for (int a = 0; a < SEC_N; a++)  chk("R6 sec_regs_o", sec[a*8 +: 8], pat(8'hAA, a, 8'h3C));
    chk("R7 ja_en_o", ja_en, pat(8'h01, 'h00, 8'h3C));
    chk("R7 ja_depth_o", ja_dep, pat(8'h01, 'h02, 8'h3C));
    chk("R7 rclk_inv_o", rinv, pat(8'h01, 'h13, 8'h3C));
    chk("R7 tclk_inv_o", tinv, pat(8'h01, 'h14, 8'h3C));

    // status: per-channel page, clear-on-read
    wr(5'h1F, 8'h01, 0);
    wr(5'h1E, 8'h00, 0);
    wr(5'h11, 8'hFF, 0);
    rd(5'h12, 0, d);              // drain
    chk("R13 irq idle", irq, 0);
    wr(5'h00, 8'h00, 8'h05);      // event alongside unrelated write
    chk("R13 irq raised", irq, 1);
    rd(5'h12, 0, d); chk("R9 status latched", d, 8'h05);
    chk("R13 irq drops after read clear", irq, 0);
    rd(5'h12, 0, d); chk("R10 read cleared", d, 8'h00);
    wr(5'h12, 8'h00, 8'h01);
    wr(5'h12, 8'hFF, 0);
    rd(5'h12, 0, d); chk("R10 write ignored in read mode", d, 8'h01);
    rd(5'h12, 8'h80, d); chk("R12 read returns old", d, 8'h00);
    rd(5'h12, 0, d); chk("R12 event survives read clear", d, 8'h80);
    // masking
    wr(5'h11, 8'h0F, 0);
    wr(5'h00, 8'h00, 8'h10);
    chk("R13 masked event no irq", irq, 0);
    wr(5'h00, 8'h00, 8'h02);
    chk("R13 unmasked event irq", irq, 1);
    rd(5'h12, 0, d); chk("R9 both bits", d, 8'h12);

    // clear-on-write
    wr(5'h1E, 8'hFF, 0);
    rd(5'h1E, 0, d); chk("R10 mode readback", d, 8'h01);
    wr(5'h11, 8'hFF, 0);
    wr(5'h00, 8'h00, 8'h0C);
    rd(5'h12, 0, d); chk("R11 status set", d, 8'h0C);
    rd(5'h12, 0, d); chk("R11 read does not clear", d, 8'h0C);
    wr(5'h12, 8'h04, 0);
    rd(5'h12, 0, d); chk("R11 selective clear", d, 8'h08);
    chk("R13 irq still up", irq, 1);
    wr(5'h12, 8'h0C, 8'h04);
    rd(5'h12, 0, d); chk("R12 event wins write clear", d, 8'h04);
    wr(5'h12, 8'hFF, 0);
    chk("R13 irq drops after write clear", irq, 0);
    rd(5'h12, 0, d); chk("R11 all cleared", d, 8'h00);

    summary();
  end
endmodule